// File: doc/BRIEF.md
# Manchester Word Receiver

This block turns a biphase serial line into 16-bit words. The line reaches it as two single-ended receiver outputs, one for each polarity. Both are resampled on a clock that runs at twelve samples per bit time, which is 12 MHz for a 1 Mbit/s line. The receiver waits for the line to come alive. It then looks for a three-bit-time synchronisation shape and tells from its polarity whether a command/status word or a data word follows. It recovers sixteen data bits and a parity bit and checks each bit for a mid-bit transition. It also checks the word for odd parity.

Each finished word produces exactly one report cycle. On that cycle, either the valid strobe is high or at least one of the error flags is high. The word and its type are updated on the same cycle. The line cannot be paused, so the output has no ready input and cannot apply back-pressure. A consumer must take the word on the strobe cycle, because the next report can come one word time later at the earliest. Checks that span a whole message, and the choice between redundant buses, belong to logic outside this block.

Top module: `mwr_word_rx`

## Requirements
- R1: While reset is asserted, and until the first report after it, every output is zero. After reset the receiver decodes nothing until it has seen an inactive sample followed by an active one. A line that is already active when reset is released is therefore ignored until it has gone inactive.
- R2: Line levels are read from the pair (`line_pos`, `line_neg`) as follows: (1,0) is a high level, (0,1) is a low level, and equal values mean the line is inactive.
- R3: A high run followed by a low level is a command/status sync, and the report for that word has `rx_is_cmd` = 1.
- R4: A low run followed by a high level is a data sync, and the report for that word has `rx_is_cmd` = 0.
- R5: The first half of the sync is accepted when its run lasts 15 to 21 samples, both limits included. A run of any other length is discarded and the hunt starts again, so no report follows.
- R6: If the second half of the sync changes level before it has lasted 15 samples, the sync is abandoned and no report follows.
- R7: Bit k occupies the 12 samples starting 18 + 12k samples after the mid-sync transition. The 17 bits are the data bits from `rx_word[15]` down to `rx_word[0]`, then the parity bit. Each bit is sampled at its 3rd and 9th sample. High-then-low decodes as 1 and low-then-high as 0. The decoded value is always the first of the two samples.
- R8: If the two samples of any of the 17 bits are equal, the report raises `rx_manch_err`.
- R9: If the 17 received bits hold an even number of ones, the report raises `rx_parity_err`.
- R10: The report comes 3 clocks after the last sample of the parity bit is presented and lasts exactly one cycle. `rx_valid` is high only when neither error flag is high. `rx_word` and `rx_is_cmd` change only on a report cycle.
- R11: A sync that starts on the sample right after a word's parity bit is decoded, whatever level that parity bit ended on.
- R12: If the line goes inactive in the middle of a word, the word is dropped without a report. Decoding resumes only after a new inactive-to-active change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twelve samples per bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos | input | 1 | Positive-polarity receiver output |
| line_neg | input | 1 | Negative-polarity receiver output |
| rx_word | output | DATA_W | Last received data field, first bit received in the MSB |
| rx_is_cmd | output | 1 | Word type of the last report: 1 for command/status sync, 0 for data sync |
| rx_valid | output | 1 | One-cycle strobe for a word with no error |
| rx_parity_err | output | 1 | One-cycle flag: the word failed odd parity |
| rx_manch_err | output | 1 | One-cycle flag: at least one bit had no mid-bit transition |

## Verification
The line is driven with words of both sync polarities, and these tell the two shapes apart both on `rx_is_cmd` and in the decoded bits. Some words are sent back to back, which shows that the hunt restarts exactly at the word boundary rather than on a level change. Sync first halves of 12, 15, 21 and 24 samples separate acceptance from rejection at both limits, and a 12-sample second half shows the early abort. Two kinds of word are spoiled: one has a bad parity bit, and the other has a bit with no transition, placed once among the data bits and once on the parity bit. Between them they show that the two error flags are raised independently. Finally, a word is sent with the line active from reset, and another is cut mid-word by an invalid (1,1) pair, to check that the receiver waits for a fresh line edge in both cases.

// File: rtl/mwr_pkg.sv
`timescale 1ns/1ps
package mwr_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_HUNT,
    FS_SYNC2,
    FS_DATA
  } frm_state_e;

  // Per-sample strobes from the framer to the bit decoder
  typedef struct packed {
    logic start;  // first data bit begins on the next sample
    logic cmd;    // sync polarity, valid with start
    logic q1;     // early sample point of a bit
    logic q3;     // late sample point of a bit
    logic last;   // final sample of the parity bit
  } frm_evt_t;

endpackage

// File: rtl/mwr_line_sync.sv
`timescale 1ns/1ps
module mwr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  output logic level,
  output logic active
);

  logic [STAGES-1:0] pos_sr;
  logic [STAGES-1:0] neg_sr;

  // Reset to a high level so that a line already active at reset shows no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_sr <= '1;
      neg_sr <= '0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        pos_sr[i] <= pos_sr[i-1];
        neg_sr[i] <= neg_sr[i-1];
      end
      pos_sr[0] <= pos_in;
      neg_sr[0] <= neg_in;
    end
  end

  assign active = pos_sr[STAGES-1] ^ neg_sr[STAGES-1];
  assign level  = pos_sr[STAGES-1];

endmodule

// File: rtl/mwr_framer.sv
`timescale 1ns/1ps
module mwr_framer
  import mwr_pkg::*;
#(
  parameter int SPB      = 12,
  parameter int DATA_W   = 16,
  parameter int SYNC_MIN = 15,
  parameter int SYNC_MAX = 21
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level,
  input  logic     active,
  output frm_evt_t evt
);

  localparam int HALF3   = (3 * SPB) / 2;
  localparam int Q1      = SPB / 4;
  localparam int Q3      = (3 * SPB) / 4;
  localparam int RUN_CAP = SYNC_MAX + 1;
  localparam int RW      = $clog2(RUN_CAP + 1);
  localparam int PW      = $clog2(HALF3 + 1);
  localparam int PHW     = $clog2(SPB + 1);
  localparam int BW      = $clog2(DATA_W + 1);

  localparam logic [RW-1:0]  RUN_LO   = RW'(SYNC_MIN);
  localparam logic [RW-1:0]  RUN_HI   = RW'(SYNC_MAX);
  localparam logic [RW-1:0]  RUN_TOP  = RW'(RUN_CAP);
  localparam logic [PW-1:0]  POS_MIN  = PW'(SYNC_MIN);
  localparam logic [PW-1:0]  POS_END  = PW'(HALF3);
  localparam logic [PHW-1:0] PH_Q1    = PHW'(Q1);
  localparam logic [PHW-1:0] PH_Q3    = PHW'(Q3);
  localparam logic [PHW-1:0] PH_END   = PHW'(SPB);
  localparam logic [BW-1:0]  BIT_LAST = BW'(DATA_W);

  frm_state_e     st_q, st_d;
  logic [RW-1:0]  run_q, run_d;
  logic           lvl_q, lvl_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [BW-1:0]  bit_q, bit_d;
  logic           cmd_q, cmd_d;
  logic           prev_act_q;
  logic           rise;
  logic [PHW-1:0] ph_idx;
  logic [PW-1:0]  pos_idx;

  assign rise    = active & ~prev_act_q;
  assign ph_idx  = ph_q + 1'b1;
  assign pos_idx = pos_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    lvl_d = lvl_q;
    pos_d = pos_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    cmd_d = cmd_q;
    evt   = '0;
    if (!active) begin
      st_d  = FS_IDLE;
      run_d = '0;
    end else begin
      unique case (st_q)
        FS_IDLE: begin
          if (rise) begin
            st_d  = FS_HUNT;
            run_d = RW'(1);
            lvl_d = level;
          end
        end
        FS_HUNT: begin
          if (run_q == '0) begin
            run_d = RW'(1);
            lvl_d = level;
          end else if (level == lvl_q) begin
            if (run_q != RUN_TOP) run_d = run_q + 1'b1;
          end else if (run_q >= RUN_LO && run_q <= RUN_HI) begin
            st_d  = FS_SYNC2;
            pos_d = PW'(1);
            cmd_d = lvl_q;
          end else begin
            run_d = RW'(1);
            lvl_d = level;
          end
        end
        FS_SYNC2: begin
          if (level == cmd_q && pos_q < POS_MIN) begin
            st_d  = FS_HUNT;
            run_d = RW'(1);
            lvl_d = level;
          end else if (pos_idx == POS_END) begin
            st_d      = FS_DATA;
            ph_d      = '0;
            bit_d     = '0;
            evt.start = 1'b1;
            evt.cmd   = cmd_q;
          end else begin
            pos_d = pos_idx;
          end
        end
        FS_DATA: begin
          evt.q1 = (ph_idx == PH_Q1);
          evt.q3 = (ph_idx == PH_Q3);
          if (ph_idx == PH_END) begin
            ph_d = '0;
            if (bit_q == BIT_LAST) begin
              evt.last = 1'b1;
              st_d     = FS_HUNT;
              run_d    = '0;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            ph_d = ph_idx;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FS_IDLE;
      run_q      <= '0;
      lvl_q      <= 1'b0;
      pos_q      <= '0;
      ph_q       <= '0;
      bit_q      <= '0;
      cmd_q      <= 1'b0;
      prev_act_q <= 1'b1;
    end else begin
      st_q       <= st_d;
      run_q      <= run_d;
      lvl_q      <= lvl_d;
      pos_q      <= pos_d;
      ph_q       <= ph_d;
      bit_q      <= bit_d;
      cmd_q      <= cmd_d;
      prev_act_q <= active;
    end
  end

endmodule

// File: rtl/mwr_word_dec.sv
`timescale 1ns/1ps
module mwr_word_dec
  import mwr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level,
  input  frm_evt_t          evt,
  output logic [DATA_W-1:0] word,
  output logic              is_cmd,
  output logic              valid,
  output logic              par_err,
  output logic              man_err
);

  localparam int SRW = DATA_W + 1;

  logic [SRW-1:0] sr_q;
  logic           first_q;
  logic           merr_q;
  logic           cmd_q;
  logic           odd;

  assign odd = ^sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      first_q <= 1'b0;
      merr_q  <= 1'b0;
      cmd_q   <= 1'b0;
      word    <= '0;
      is_cmd  <= 1'b0;
      valid   <= 1'b0;
      par_err <= 1'b0;
      man_err <= 1'b0;
    end else begin
      valid   <= 1'b0;
      par_err <= 1'b0;
      man_err <= 1'b0;
      if (evt.start) begin
        merr_q <= 1'b0;
        cmd_q  <= evt.cmd;
      end
      if (evt.q1) first_q <= level;
      if (evt.q3) begin
        sr_q <= {sr_q[SRW-2:0], first_q};
        if (first_q == level) merr_q <= 1'b1;
      end
      if (evt.last) begin
        word    <= sr_q[SRW-1:1];
        is_cmd  <= cmd_q;
        valid   <= odd & ~merr_q;
        par_err <= ~odd;
        man_err <= merr_q;
      end
    end
  end

endmodule

// File: rtl/mwr_word_rx.sv
`timescale 1ns/1ps
module mwr_word_rx
  import mwr_pkg::*;
#(
  parameter int SPB         = 12,
  parameter int DATA_W      = 16,
  parameter int SYNC_MIN    = 15,
  parameter int SYNC_MAX    = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pos,
  input  logic              line_neg,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_is_cmd,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_manch_err
);

  logic     s_level;
  logic     s_active;
  frm_evt_t evt;

  mwr_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pos_in (line_pos),
    .neg_in (line_neg),
    .level  (s_level),
    .active (s_active)
  );

  mwr_framer #(
    .SPB      (SPB),
    .DATA_W   (DATA_W),
    .SYNC_MIN (SYNC_MIN),
    .SYNC_MAX (SYNC_MAX)
  ) u_frm (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (s_level),
    .active (s_active),
    .evt    (evt)
  );

  mwr_word_dec #(
    .DATA_W(DATA_W)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (s_level),
    .evt     (evt),
    .word    (rx_word),
    .is_cmd  (rx_is_cmd),
    .valid   (rx_valid),
    .par_err (rx_parity_err),
    .man_err (rx_manch_err)
  );

endmodule

// File: rtl/mwr_word_rx_chk.sv
`timescale 1ns/1ps
module mwr_word_rx_chk #(
  parameter int DATA_W = 16,
  parameter int LAG    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_pos,
  input logic              line_neg,
  input logic [DATA_W-1:0] rx_word,
  input logic              rx_is_cmd,
  input logic              rx_valid,
  input logic              rx_parity_err,
  input logic              rx_manch_err
);

  logic report;
  assign report = rx_valid | rx_parity_err | rx_manch_err;

  p_valid_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !(rx_parity_err || rx_manch_err));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_perr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_parity_err |=> !rx_parity_err);

  p_merr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_manch_err |=> !rx_manch_err);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !report |-> ($stable(rx_word) && $stable(rx_is_cmd)));

  p_active_line_r12: assert property (@(posedge clk) disable iff (!rst_n)
    report |-> $past(line_pos != line_neg, LAG));

endmodule

bind mwr_word_rx mwr_word_rx_chk #(
  .DATA_W (DATA_W),
  .LAG    (SYNC_STAGES + 1)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_pos      (line_pos),
  .line_neg      (line_neg),
  .rx_word       (rx_word),
  .rx_is_cmd     (rx_is_cmd),
  .rx_valid      (rx_valid),
  .rx_parity_err (rx_parity_err),
  .rx_manch_err  (rx_manch_err)
);

// File: tb/mwr_word_rx_tb.sv
`timescale 1ns/1ps
module mwr_word_rx_tb;

  localparam int SPB  = 12;
  localparam int DW   = 16;
  localparam int HALF = SPB / 2;
  localparam int LAG  = 3;
  localparam logic [1:0] C_HI = 2'b10;
  localparam logic [1:0] C_LO = 2'b01;
  localparam logic [1:0] C_ID = 2'b00;
  localparam logic [1:0] C_BH = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_pos = 1'b0;
  logic          line_neg = 1'b0;
  logic [DW-1:0] rx_word;
  logic          rx_is_cmd, rx_valid, rx_parity_err, rx_manch_err;

  always #2.5 clk = ~clk;

  mwr_word_rx u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_pos      (line_pos),
    .line_neg      (line_neg),
    .rx_word       (rx_word),
    .rx_is_cmd     (rx_is_cmd),
    .rx_valid      (rx_valid),
    .rx_parity_err (rx_parity_err),
    .rx_manch_err  (rx_manch_err)
  );

  typedef struct {
    int            t;
    logic [DW-1:0] w;
    bit            cmd;
    bit            v;
    bit            pe;
    bit            me;
    string         tag;
  } ev_t;

  logic [1:0] smp_q[$];
  string      tag_q[$];
  ev_t        ev_q[$];
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  task automatic put(input logic [1:0] c, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      smp_q.push_back(c);
      tag_q.push_back(tag);
    end
  endtask

  function automatic logic [1:0] lv(input bit b);
    return b ? C_HI : C_LO;
  endfunction

  // Sync halves h1/h2, nbits of the 17 bits, bit mbit without transition
  task automatic send_word(input bit cmd, input logic [DW-1:0] d, input bit bad_par,
                           input int mbit, input int h1, input int h2, input int nbits,
                           input bit expect_rep, input string tag);
    bit  par;
    ev_t e;
    par = ~(^d) ^ bad_par;
    put(lv(cmd), tag, h1);
    put(lv(!cmd), tag, h2);
    for (int k = 0; k < nbits; k++) begin
      bit b;
      b = (k < DW) ? d[DW-1-k] : par;
      put(lv(b), tag, HALF);
      put(lv((k == mbit) ? b : !b), tag, HALF);
    end
    if (expect_rep) begin
      e.t   = smp_q.size() - 1 + LAG;
      e.w   = d;
      e.cmd = cmd;
      e.pe  = bad_par;
      e.me  = (mbit >= 0);
      e.v   = !e.pe && !e.me;
      e.tag = tag;
      ev_q.push_back(e);
    end
  endtask

  task automatic check_cycle(input int n);
    bit    hit, ev_v, ev_pe, ev_me;
    string tag;
    hit   = (ev_q.size() > 0) && (ev_q[0].t == n);
    ev_v  = hit ? ev_q[0].v  : 1'b0;
    ev_pe = hit ? ev_q[0].pe : 1'b0;
    ev_me = hit ? ev_q[0].me : 1'b0;
    if (hit) tag = ev_q[0].tag;
    else if (n >= LAG && (n - LAG) < tag_q.size()) tag = tag_q[n - LAG];
    else tag = "R1/R10 quiet";
    checks++;
    if (rx_valid !== ev_v || rx_parity_err !== ev_pe || rx_manch_err !== ev_me) begin
      fails++;
      $display("FAIL %s cycle %0d flags v/pe/me actual %b%b%b expected %b%b%b",
               tag, n, rx_valid, rx_parity_err, rx_manch_err, ev_v, ev_pe, ev_me);
    end
    if (hit) begin
      checks++;
      if (rx_word !== ev_q[0].w || rx_is_cmd !== ev_q[0].cmd) begin
        fails++;
        $display("FAIL %s cycle %0d word/cmd actual %h/%b expected %h/%b",
                 tag, n, rx_word, rx_is_cmd, ev_q[0].w, ev_q[0].cmd);
      end
      void'(ev_q.pop_front());
    end
  endtask

  initial begin
    int total;
    // R1: line active from reset onward, word must be ignored
    send_word(1'b1, 16'h1234, 1'b0, -1, 18, 18, 17, 1'b0, "R1 active-at-reset");
    put(C_ID, "R1", 20);
    // R3 R7: command word
    send_word(1'b1, 16'hA5C3, 1'b0, -1, 18, 18, 17, 1'b1, "R3 R7 cmd");
    // R4 R11: back-to-back data words
    send_word(1'b0, 16'h0001, 1'b0, -1, 18, 18, 17, 1'b1, "R4 R11 data");
    send_word(1'b0, 16'hFFFF, 1'b0, -1, 18, 18, 17, 1'b1, "R11 data2");
    send_word(1'b0, 16'h0000, 1'b0, -1, 18, 18, 17, 1'b1, "R11 data3");
    put(C_ID, "R10", 10);
    send_word(1'b1, 16'h8001, 1'b1, -1, 18, 18, 17, 1'b1, "R9 parity");
    put(C_ID, "R9", 10);
    send_word(1'b0, 16'h5555, 1'b0, 4, 18, 18, 17, 1'b1, "R8 manch data bit");
    put(C_ID, "R8", 10);
    send_word(1'b1, 16'h0F0F, 1'b0, 16, 18, 18, 17, 1'b1, "R8 manch parity bit");
    put(C_ID, "R8", 10);
    send_word(1'b1, 16'h1111, 1'b0, -1, 12, 18, 17, 1'b0, "R5 short half");
    put(C_ID, "R5", 10);
    send_word(1'b1, 16'h1111, 1'b0, -1, 24, 18, 17, 1'b0, "R5 long half");
    put(C_ID, "R5", 10);
    send_word(1'b1, 16'h2222, 1'b0, -1, 15, 18, 17, 1'b1, "R5 min half");
    put(C_ID, "R5", 10);
    send_word(1'b0, 16'h7FFE, 1'b0, -1, 21, 18, 17, 1'b1, "R5 R4 max half");
    put(C_ID, "R5", 10);
    send_word(1'b1, 16'hB333, 1'b0, -1, 18, 12, 17, 1'b0, "R6 short second");
    put(C_ID, "R6", 10);
    send_word(1'b0, 16'h4321, 1'b0, -1, 18, 18, 8, 1'b0, "R12 cut");
    put(C_BH, "R2 R12 both-high", 5);
    put(C_ID, "R12", 10);
    send_word(1'b1, 16'h0F0F, 1'b0, -1, 18, 18, 17, 1'b1, "R12 recover");
    put(C_ID, "R10", 20);
    total = smp_q.size();

    repeat (4) @(negedge clk);
    // R1: outputs at reset
    checks++;
    if (rx_word !== '0 || rx_is_cmd !== 1'b0 || rx_valid !== 1'b0 ||
        rx_parity_err !== 1'b0 || rx_manch_err !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %h %b%b%b%b expected 0",
               rx_word, rx_is_cmd, rx_valid, rx_parity_err, rx_manch_err);
    end
    rst_n = 1'b1;
    for (int n = 0; n < total + LAG + 4; n++) begin
      logic [1:0] c;
      if (n > 0) @(negedge clk);
      check_cycle(n);
      c = (n < total) ? smp_q[n] : C_ID;
      line_pos = c[1];
      line_neg = c[0];
    end
    checks++;
    if (ev_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing reports actual %0d left expected 0", ev_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule